// File: doc/BRIEF.md
# SCL Phase Timing Generator

This block paces the clock line of an I2C master. A 32-bit divider word carries two independent 16-bit dividers, one for the low phase and one for the high phase of SCL. Each divider unit stands for eight input clock cycles, and the hardware adds one unit on top of the programmed value. While the controller is enabled, the block alternates low and high phases. It also gives the transfer sequencer single-cycle strobes at four points: each SCL edge, the data-change point in the middle of the low phase, and the sample point in the middle of the high phase.

For a repeated START, the sequencer raises a request that is sampled where a low phase ends. The high phase that follows is then stretched to twice its programmed length. A separate strobe, at seven eighths of the programmed high time, tells the sequencer when to pull SDA low.

The divider word is sampled only at phase boundaries. A phase that is already running is never shortened or lengthened by a new value. When the block is disabled, the counter stops and SCL is released high.

Top module: `scl_phase_gen`

## Requirements
- R1: The low-phase divider is taken from bits [15:0] of `div_word_i` and the high-phase divider from bits [31:16].
- R2: A low phase (`scl_o` = 0) lasts exactly (div_low + 1) × 8 input clock cycles.
- R3: Without a repeated START, a high phase (`scl_o` = 1) lasts exactly (div_high + 1) × 8 cycles.
- R4: `change_stb_o` pulses for one cycle exactly (div_low + 1) × 4 cycles after `fall_stb_o`, while SCL is low.
- R5: `fall_stb_o` and `rise_stb_o` pulse for one cycle in the first cycle of each low and high phase. `sample_stb_o` pulses (div_high + 1) × 4 cycles after `rise_stb_o`. At most one strobe is active in any cycle.
- R6: While `enable_i` is 0, `scl_o` is 1 and no strobe fires. After `enable_i` rises, a low phase starts on the next cycle with `fall_stb_o`.
- R7: If `rstart_i` is 1 in the last cycle of a low phase, the next high phase lasts 2 × (div_high + 1) × 8 cycles. The request affects only that one high phase.
- R8: `sda_drop_o` pulses once, (div_high + 1) × 7 cycles after `rise_stb_o`, and only in a stretched high phase.
- R9: Each phase uses the divider value present in its first cycle. A change made in the middle of a phase takes effect at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Controller enable; when 0, the counter stops and SCL is released |
| div_word_i | input | 32 | Divider word: high divider in [31:16], low divider in [15:0] |
| rstart_i | input | 1 | Repeated-START request, sampled at the end of a low phase |
| scl_o | output | 1 | SCL level (1 = released) |
| fall_stb_o | output | 1 | First cycle of a low phase |
| change_stb_o | output | 1 | Data-change point in the middle of the low phase |
| rise_stb_o | output | 1 | First cycle of a high phase |
| sample_stb_o | output | 1 | Sample point in the middle of the programmed high time |
| sda_drop_o | output | 1 | SDA pull-down point of a repeated START |

## Verification
Two functions can meet in the same cycle: loading a new divider value and closing the current phase. The bench changes the high divider in the last cycle of a low phase and expects the high phase that follows to take the new length at once. It also changes the low divider in the middle of a low phase and expects that phase to keep its old length, with the new length appearing only in the next low phase. The repeated-START request is tested the same way: it is held across the low-to-high boundary, and the bench checks that exactly the next high phase is stretched and that the following one is not.

// File: rtl/scl_pkg.sv
package scl_pkg;
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/scl_marks.sv
// Derives the last count, midpoint and seven-eighths point of the current phase.
module scl_marks #(
    parameter int DIV_W     = 16,
    parameter int UNIT_LOG2 = 3,   // must be at least 3 for the 7/8 point
    parameter int CNT_W     = DIV_W + UNIT_LOG2 + 2
) (
    input  logic [DIV_W-1:0] div_i,
    input  logic             stretch_i,
    output logic [CNT_W-1:0] last_o,
    output logic [CNT_W-1:0] mid_o,
    output logic [CNT_W-1:0] late_o
);
    logic [CNT_W-1:0] units;
    logic [CNT_W-1:0] span;

    always_comb begin
        units  = CNT_W'(div_i) + CNT_W'(1);
        span   = units << UNIT_LOG2;
        mid_o  = units << (UNIT_LOG2 - 1);
        late_o = span - (units << (UNIT_LOG2 - 3));
        last_o = (stretch_i ? (span << 1) : span) - CNT_W'(1);
    end
endmodule

// File: rtl/scl_phase_fsm.sv
// Phase sequencer: off / low / high, with the divider latched at each boundary.
module scl_phase_fsm
    import scl_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int CNT_W = 21
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic [DIV_W-1:0] div_low_i,
    input  logic [DIV_W-1:0] div_high_i,
    input  logic             rstart_i,
    input  logic [CNT_W-1:0] last_i,
    output phase_e           phase_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [DIV_W-1:0] div_o,
    output logic             stretch_o
);
    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic             stretch;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable_i) begin
            st_d.phase   = PH_OFF;
            st_d.cnt     = '0;
            st_d.stretch = 1'b0;
        end else begin
            unique case (st_q.phase)
                PH_OFF: begin
                    st_d.phase = PH_LOW;
                    st_d.cnt   = '0;
                    st_d.div   = div_low_i;
                end
                PH_LOW: begin
                    if (st_q.cnt == last_i) begin
                        st_d.phase   = PH_HIGH;
                        st_d.cnt     = '0;
                        st_d.div     = div_high_i;
                        st_d.stretch = rstart_i;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (st_q.cnt == last_i) begin
                        st_d.phase   = PH_LOW;
                        st_d.cnt     = '0;
                        st_d.div     = div_low_i;
                        st_d.stretch = 1'b0;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                default: begin
                    st_d.phase = PH_OFF;
                    st_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.phase   <= PH_OFF;
            st_q.cnt     <= '0;
            st_q.div     <= '0;
            st_q.stretch <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o   = st_q.phase;
    assign cnt_o     = st_q.cnt;
    assign div_o     = st_q.div;
    assign stretch_o = st_q.stretch;
endmodule

// File: rtl/scl_strobe_dec.sv
// Decodes the SCL level and the bit-phase strobes from the sequencer state.
module scl_strobe_dec
    import scl_pkg::*;
#(
    parameter int CNT_W = 21
) (
    input  phase_e           phase_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] mid_i,
    input  logic [CNT_W-1:0] late_i,
    input  logic             stretch_i,
    output logic             scl_o,
    output logic             fall_o,
    output logic             change_o,
    output logic             rise_o,
    output logic             sample_o,
    output logic             drop_o
);
    logic in_low, in_high, at_start;

    always_comb begin
        in_low   = (phase_i == PH_LOW);
        in_high  = (phase_i == PH_HIGH);
        at_start = (cnt_i == '0);
        scl_o    = !in_low;
        fall_o   = in_low  && at_start;
        change_o = in_low  && (cnt_i == mid_i);
        rise_o   = in_high && at_start;
        sample_o = in_high && (cnt_i == mid_i);
        drop_o   = in_high && stretch_i && (cnt_i == late_i);
    end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int UNIT_LOG2 = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               enable_i,
    input  logic [2*DIV_W-1:0] div_word_i,
    input  logic               rstart_i,
    output logic               scl_o,
    output logic               fall_stb_o,
    output logic               change_stb_o,
    output logic               rise_stb_o,
    output logic               sample_stb_o,
    output logic               sda_drop_o
);
    localparam int CNT_W = DIV_W + UNIT_LOG2 + 2;

    phase_e           phase;
    logic [CNT_W-1:0] cnt, last_idx, mid_idx, late_idx;
    logic [DIV_W-1:0] cur_div;
    logic             stretch;

    // R1: low divider in the lower half of the word, high divider in the upper half
    scl_phase_fsm #(.DIV_W(DIV_W), .CNT_W(CNT_W)) i_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (enable_i),
        .div_low_i  (div_word_i[DIV_W-1:0]),
        .div_high_i (div_word_i[2*DIV_W-1:DIV_W]),
        .rstart_i   (rstart_i),
        .last_i     (last_idx),
        .phase_o    (phase),
        .cnt_o      (cnt),
        .div_o      (cur_div),
        .stretch_o  (stretch)
    );

    scl_marks #(.DIV_W(DIV_W), .UNIT_LOG2(UNIT_LOG2), .CNT_W(CNT_W)) i_marks (
        .div_i     (cur_div),
        .stretch_i (stretch),
        .last_o    (last_idx),
        .mid_o     (mid_idx),
        .late_o    (late_idx)
    );

    scl_strobe_dec #(.CNT_W(CNT_W)) i_dec (
        .phase_i   (phase),
        .cnt_i     (cnt),
        .mid_i     (mid_idx),
        .late_i    (late_idx),
        .stretch_i (stretch),
        .scl_o     (scl_o),
        .fall_o    (fall_stb_o),
        .change_o  (change_stb_o),
        .rise_o    (rise_stb_o),
        .sample_o  (sample_stb_o),
        .drop_o    (sda_drop_o)
    );
endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic enable_i,
    input logic scl_o,
    input logic fall_stb_o,
    input logic change_stb_o,
    input logic rise_stb_o,
    input logic sample_stb_o,
    input logic sda_drop_o
);
    assert_fall_opens_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(scl_o) |-> fall_stb_o);

    assert_rise_opens_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(scl_o) && $past(enable_i)) |-> rise_stb_o);

    assert_single_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({fall_stb_o, change_stb_o, rise_stb_o, sample_stb_o, sda_drop_o}));

    assert_quiet_when_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(enable_i) |-> (scl_o && !fall_stb_o && !change_stb_o && !rise_stb_o
                              && !sample_stb_o && !sda_drop_o));

    assert_change_in_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        change_stb_o |-> !scl_o);

    assert_drop_in_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sda_drop_o |-> (scl_o && !rise_stb_o));
endmodule

bind scl_phase_gen scl_phase_gen_chk i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .scl_o        (scl_o),
    .fall_stb_o   (fall_stb_o),
    .change_stb_o (change_stb_o),
    .rise_stb_o   (rise_stb_o),
    .sample_stb_o (sample_stb_o),
    .sda_drop_o   (sda_drop_o)
);

// File: tb/test_scl_phase_gen.sv
module test_scl_phase_gen;
    localparam int LIMIT = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] div_word = '0;
    logic        rstart = 1'b0;
    logic        scl, fall_stb, change_stb, rise_stb, sample_stb, sda_drop;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    scl_phase_gen i_scl_phase_gen (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .enable_i     (enable),
        .div_word_i   (div_word),
        .rstart_i     (rstart),
        .scl_o        (scl),
        .fall_stb_o   (fall_stb),
        .change_stb_o (change_stb),
        .rise_stb_o   (rise_stb),
        .sample_stb_o (sample_stb),
        .sda_drop_o   (sda_drop)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_fall();
        int g = 0;
        while (!fall_stb && g < LIMIT) begin
            @(negedge clk);
            g++;
        end
        chk("R5 fall strobe seen", int'(fall_stb), 1);
    endtask

    // Measures one low phase and the high phase after it, starting at a fall strobe.
    task automatic measure(output int lo, output int chg, output int hi,
                           output int smp, output int drp);
        wait_fall();
        lo = 0; chg = -1;
        do begin
            @(negedge clk);
            lo++;
            if (change_stb) chg = lo;
        end while (!rise_stb && lo < LIMIT);
        hi = 0; smp = -1; drp = -1;
        do begin
            @(negedge clk);
            hi++;
            if (sample_stb) smp = hi;
            if (sda_drop) drp = hi;
        end while (!fall_stb && hi < LIMIT);
    endtask

    task automatic set_divs(input int dl, input int dh);
        div_word = {dh[15:0], dl[15:0]};
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R6 scl released in reset", int'(scl), 1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R6 scl released while off", int'(scl), 1);
        chk("R6 no strobes while off",
            int'(fall_stb | change_stb | rise_stb | sample_stb | sda_drop), 0);
    endtask

    task automatic t_basic(input int dl, input int dh);
        int lo, chg, hi, smp, drp;
        set_divs(dl, dh);
        measure(lo, chg, hi, smp, drp);
        chk("R2 low length", lo, (dl + 1) * 8);
        chk("R4 change point", chg, (dl + 1) * 4);
        chk("R3 high length", hi, (dh + 1) * 8);
        chk("R5 sample point", smp, (dh + 1) * 4);
        chk("R8 no drop without restart", drp, -1);
    endtask

    task automatic t_fields();
        int lo, chg, hi, smp, drp;
        div_word = 32'h0001_0003;   // R1: high=1, low=3
        @(negedge clk);
        measure(lo, chg, hi, smp, drp);
        chk("R1 low field [15:0]", lo, 32);
        chk("R1 high field [31:16]", hi, 16);
    endtask

    task automatic t_restart();
        int lo, chg, hi, smp, drp;
        set_divs(0, 3);
        rstart = 1'b1;
        @(negedge clk);
        measure(lo, chg, hi, smp, drp);
        rstart = 1'b0;
        chk("R7 stretched high length", hi, 64);
        chk("R8 drop at 7/8 of programmed high", drp, 28);
        chk("R5 sample in stretched high", smp, 16);
        @(negedge clk);
        measure(lo, chg, hi, smp, drp);
        chk("R7 next high not stretched", hi, 32);
        chk("R8 no drop after restart", drp, -1);
    endtask

    task automatic t_update();
        int lo, hi;
        set_divs(1, 1);
        wait_fall();
        lo = 0;
        do begin
            @(negedge clk);
            lo++;
            if (lo == 2) div_word[15:0] = 16'd3;    // mid-phase low change
            if (lo == 15) div_word[31:16] = 16'd2;  // last low cycle: high change
        end while (!rise_stb && lo < LIMIT);
        chk("R9 mid-phase change ignored", lo, 16);
        hi = 0;
        do begin
            @(negedge clk);
            hi++;
        end while (!fall_stb && hi < LIMIT);
        chk("R9 high takes value at boundary", hi, 24);
        lo = 0;
        do begin
            @(negedge clk);
            lo++;
        end while (!rise_stb && lo < LIMIT);
        chk("R9 next low takes new value", lo, 32);
    endtask

    task automatic t_disable();
        int seen = 0;
        int lit  = 0;
        set_divs(2, 2);
        wait_fall();
        repeat (3) @(negedge clk);
        enable = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (!scl) lit++;
            if (fall_stb | change_stb | rise_stb | sample_stb | sda_drop) seen++;
        end
        chk("R6 scl high after disable", lit, 0);
        chk("R6 no strobes after disable", seen, 0);
        enable = 1'b1;
        @(negedge clk);
        chk("R6 fall strobe one cycle after enable", int'(fall_stb), 1);
        chk("R6 scl low after enable", int'(scl), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        enable = 1'b1;
        t_basic(0, 0);
        t_basic(5, 2);
        t_fields();
        t_restart();
        t_update();
        t_disable();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule